// File: doc/BRIEF.md
# Shared Memory Bank Conflict Resolver

This block takes one 32-lane warp load and splits it into bank-conflict-free wavefronts for a banked shared memory. Each lane carries an enable bit, a predicate bit and a 32-bit generic address. The block first drops lanes that are disabled or predicated off. It subtracts a programmable window base from each remaining address to get a shared memory offset, and checks every live offset against the configured memory size.

If the checks pass, the block emits one wavefront per cycle while the downstream side is ready. Each wavefront tells every bank whether it is used, which row it reads, and which lanes receive that bank's word. Lanes are picked by lowest-lane priority. The lowest live lane that targets a bank fixes that bank's row for the wavefront. Any other live lane that targets the same bank and the same row shares the access. The remaining lanes are carried into later wavefronts. Bank storage and the data return path sit downstream.

Top module: `smemResolver`

## Requirements
- R1: A lane is live only when both its enable bit and its predicate bit are 1. Lanes that are not live never appear in any lane mask, and their addresses play no part in the range check.
- R2: A lane's offset is its address minus `winBase`, computed modulo 2^32.
- R3: If any live lane's offset is greater than or equal to `memSize`, then in the cycle after acceptance `done` and `error` are both 1 and no wavefront is issued. An address below the base wraps to a large offset and also trips this check.
- R4: The bank number is offset bits [6:2]. The row is offset bits [31:7]. The row chosen for bank b appears on `wfRowSel[b*25 +: 25]` whenever `wfBankValid[b]` is 1.
- R5: Within a wavefront, the lowest-numbered live lane that targets a bank claims that bank's row. A higher live lane joins the wavefront only if it targets the same bank and the same row.
- R6: Bit i of `wfLaneMask[b*32 +: 32]` is 1 exactly when lane i is served by bank b in this wavefront. `wfBankValid[b]` is 1 exactly when that mask is nonzero. Each lane is served in exactly one wavefront.
- R7: The first wavefront is presented in the cycle after acceptance. A wavefront advances only on a cycle with `wfValid` and `wfReady` both high, and it holds stable while `wfReady` is low.
- R8: `reqReady` is 1 when idle and 0 from acceptance until the cycle after the final wavefront or completion. `done` is 1 together with the wavefront that serves the last live lane.
- R9: A request with no live lane completes in the cycle after acceptance, with `done` set, `error` clear and no wavefront.
- R10: When all 32 live lanes target one bank in 32 distinct rows, the request takes 32 wavefronts with one lane each, in ascending lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winBase | input | 32 | Base of the shared window in the generic address space |
| memSize | input | 32 | Size of shared memory in bytes |
| reqValid | input | 1 | A load request is offered |
| reqReady | output | 1 | The block can accept a request |
| reqActive | input | 32 | Per-lane enable bits |
| reqPred | input | 32 | Per-lane predicate bits |
| reqAddr | input | 1024 | Per-lane generic addresses; lane i at bits [i*32 +: 32] |
| wfValid | output | 1 | A wavefront is presented |
| wfReady | input | 1 | Downstream takes the wavefront |
| wfRowSel | output | 800 | Per-bank row select; bank b at bits [b*25 +: 25] |
| wfBankValid | output | 32 | Per-bank access enable |
| wfLaneMask | output | 1024 | Per-bank lane mask; bank b at bits [b*32 +: 32] |
| done | output | 1 | Request finishes this cycle |
| error | output | 1 | Out-of-range offset; valid together with done |

## Verification
Every result of the block is due exactly one clock edge after the event that causes it. The first wavefront, an error completion and an empty completion each appear in the cycle after the accepting edge. Each later wavefront appears in the cycle after an edge on which `wfReady` was high. The bench drives its inputs on the falling edge and checks outputs on the following falling edge, so each check lands in the cycle where its result is due. For every wavefront, the bench compares the bank enables, the lane masks, the rows of the used banks and `done` against its own lowest-lane grouping model. It counts the wavefronts and checks that `reqReady` returns one cycle after the last wavefront.

// File: rtl/smemPkg.sv
package smemPkg;
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // current wavefront taken downstream
  } dpStrobe_t;
endpackage

// File: rtl/wavePicker.sv
module wavePicker #(
  parameter int NUM_LANES = 32,
  parameter int NUM_BANKS = 32,
  parameter int ADDR_W    = 32
) (
  input  logic [NUM_LANES*ADDR_W-1:0]                  laneOffset,
  input  logic [NUM_LANES-1:0]                         liveLanes,
  output logic [NUM_BANKS*(ADDR_W-2-$clog2(NUM_BANKS))-1:0] rowSel,
  output logic [NUM_BANKS-1:0]                         bankValid,
  output logic [NUM_BANKS*NUM_LANES-1:0]               laneMask,
  output logic [NUM_LANES-1:0]                         servedLanes
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int ROW_LSB = 2 + BANK_W;
  localparam int ROW_W   = ADDR_W - ROW_LSB;

  logic [BANK_W-1:0] laneBank [NUM_LANES];
  logic [ROW_W-1:0]  laneRow  [NUM_LANES];

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      laneBank[i] = laneOffset[i*ADDR_W+2 +: BANK_W];
      laneRow[i]  = laneOffset[i*ADDR_W+ROW_LSB +: ROW_W];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    localparam logic [BANK_W-1:0] BANK_ID = BANK_W'(b);
    logic [NUM_LANES-1:0] hit;
    logic [NUM_LANES-1:0] mask;
    logic [ROW_W-1:0]     ownerRow;
    logic                 claimed;

    always_comb begin
      ownerRow = '0;
      claimed  = 1'b0;
      for (int i = 0; i < NUM_LANES; i++) begin
        hit[i] = liveLanes[i] && (laneBank[i] == BANK_ID);
        if (hit[i] && !claimed) begin
          ownerRow = laneRow[i];
          claimed  = 1'b1;
        end
      end
      for (int i = 0; i < NUM_LANES; i++) begin
        mask[i] = hit[i] && (laneRow[i] == ownerRow);
      end
    end

    assign rowSel[b*ROW_W +: ROW_W]         = ownerRow;
    assign bankValid[b]                     = claimed;
    assign laneMask[b*NUM_LANES +: NUM_LANES] = mask;
  end

  always_comb begin
    servedLanes = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      servedLanes = servedLanes | laneMask[b*NUM_LANES +: NUM_LANES];
    end
  end
endmodule

// File: rtl/smemDatapath.sv
module smemDatapath
  import smemPkg::*;
#(
  parameter int NUM_LANES = 32,
  parameter int NUM_BANKS = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]             winBase,
  input  logic [ADDR_W-1:0]             memSize,
  input  logic [NUM_LANES-1:0]          reqActive,
  input  logic [NUM_LANES-1:0]          reqPred,
  input  logic [NUM_LANES*ADDR_W-1:0]   reqAddr,
  output logic [NUM_BANKS*(ADDR_W-2-$clog2(NUM_BANKS))-1:0] rowSel,
  output logic [NUM_BANKS-1:0]          bankValid,
  output logic [NUM_BANKS*NUM_LANES-1:0] laneMask,
  output logic                          anyLive,
  output logic                          lastWave,
  output logic                          oobHit
);
  logic [NUM_LANES*ADDR_W-1:0] offsetQ, offsetD;
  logic [NUM_LANES-1:0]        liveQ, liveIn, served;
  logic                        oobQ, oobD;

  assign liveIn = reqActive & reqPred;

  always_comb begin
    oobD = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      offsetD[i*ADDR_W +: ADDR_W] = reqAddr[i*ADDR_W +: ADDR_W] - winBase;
      if (liveIn[i] && (offsetD[i*ADDR_W +: ADDR_W] >= memSize)) oobD = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ <= '0;
      liveQ   <= '0;
      oobQ    <= 1'b0;
    end else if (strobe.load) begin
      offsetQ <= offsetD;
      liveQ   <= liveIn;
      oobQ    <= oobD;
    end else if (strobe.advance) begin
      liveQ   <= liveQ & ~served;
    end
  end

  wavePicker #(
    .NUM_LANES(NUM_LANES), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
  ) pickI (
    .laneOffset (offsetQ),
    .liveLanes  (liveQ),
    .rowSel     (rowSel),
    .bankValid  (bankValid),
    .laneMask   (laneMask),
    .servedLanes(served)
  );

  assign anyLive  = |liveQ;
  assign lastWave = ~|(liveQ & ~served);
  assign oobHit   = oobQ;
endmodule

// File: rtl/smemCtrl.sv
module smemCtrl
  import smemPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      wfReady,
  input  logic      anyLive,
  input  logic      lastWave,
  input  logic      oobHit,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      wfValid,
  output logic      done,
  output logic      error
);
  typedef enum logic {IDLE, BUSY} ctrlState_t;
  ctrlState_t stateQ, stateD;

  always_comb begin
    stateD         = stateQ;
    strobe         = '0;
    reqReady       = 1'b0;
    wfValid        = 1'b0;
    done           = 1'b0;
    error          = 1'b0;
    case (stateQ)
      IDLE: begin
        reqReady    = 1'b1;
        strobe.load = reqValid;
        if (reqValid) stateD = BUSY;
      end
      BUSY: begin
        if (oobHit || !anyLive) begin
          done   = 1'b1;
          error  = oobHit;
          stateD = IDLE;
        end else begin
          wfValid        = 1'b1;
          done           = lastWave;
          strobe.advance = wfReady;
          if (wfReady && lastWave) stateD = IDLE;
        end
      end
      default: stateD = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/smemResolver.sv
module smemResolver
  import smemPkg::*;
#(
  parameter int NUM_LANES = 32,
  parameter int NUM_BANKS = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             winBase,
  input  logic [ADDR_W-1:0]             memSize,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [NUM_LANES-1:0]          reqActive,
  input  logic [NUM_LANES-1:0]          reqPred,
  input  logic [NUM_LANES*ADDR_W-1:0]   reqAddr,
  output logic                          wfValid,
  input  logic                          wfReady,
  output logic [NUM_BANKS*(ADDR_W-2-$clog2(NUM_BANKS))-1:0] wfRowSel,
  output logic [NUM_BANKS-1:0]          wfBankValid,
  output logic [NUM_BANKS*NUM_LANES-1:0] wfLaneMask,
  output logic                          done,
  output logic                          error
);
  dpStrobe_t strobe;
  logic anyLive, lastWave, oobHit;

  smemCtrl ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wfReady(wfReady),
    .anyLive(anyLive), .lastWave(lastWave), .oobHit(oobHit),
    .strobe(strobe), .reqReady(reqReady), .wfValid(wfValid),
    .done(done), .error(error)
  );

  smemDatapath #(
    .NUM_LANES(NUM_LANES), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .winBase(winBase), .memSize(memSize),
    .reqActive(reqActive), .reqPred(reqPred), .reqAddr(reqAddr),
    .rowSel(wfRowSel), .bankValid(wfBankValid), .laneMask(wfLaneMask),
    .anyLive(anyLive), .lastWave(lastWave), .oobHit(oobHit)
  );
endmodule

// File: rtl/smemResolverChk.sv
module smemResolverChk #(
  parameter int NUM_LANES = 32,
  parameter int NUM_BANKS = 32,
  parameter int ADDR_W    = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          reqValid,
  input logic                          reqReady,
  input logic [NUM_LANES-1:0]          reqActive,
  input logic [NUM_LANES-1:0]          reqPred,
  input logic                          wfValid,
  input logic                          wfReady,
  input logic [NUM_BANKS*(ADDR_W-2-$clog2(NUM_BANKS))-1:0] wfRowSel,
  input logic [NUM_BANKS-1:0]          wfBankValid,
  input logic [NUM_BANKS*NUM_LANES-1:0] wfLaneMask,
  input logic                          done,
  input logic                          error
);
  logic [NUM_LANES-1:0] unionMask;
  logic [NUM_BANKS-1:0] nonEmpty;
  int unsigned          bitTotal;

  always_comb begin
    unionMask = '0;
    bitTotal  = 0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      unionMask   = unionMask | wfLaneMask[b*NUM_LANES +: NUM_LANES];
      nonEmpty[b] = |wfLaneMask[b*NUM_LANES +: NUM_LANES];
      bitTotal    = bitTotal + $countones(wfLaneMask[b*NUM_LANES +: NUM_LANES]);
    end
  end

  // R3
  error_no_wave_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done && !wfValid);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    wfValid |-> !reqReady);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wfValid && !wfReady |=> wfValid && $stable(wfLaneMask) && $stable(wfBankValid));

  // R6
  lane_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    wfValid |-> bitTotal == $countones(unionMask) && unionMask != '0);

  // R6
  bank_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    wfValid |-> wfBankValid == nonEmpty);

  // R9
  empty_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && ((reqActive & reqPred) == '0) |=> done && !error && !wfValid);
endmodule

bind smemResolver smemResolverChk #(
  .NUM_LANES(NUM_LANES), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) chkI (.*);

// File: tb/smemResolver_test.sv
module smemResolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int NB = 32;
  localparam int AW = 32;
  localparam int RW = AW - 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] winBase = 32'h7000_0000;
  logic [AW-1:0] memSize = 32'h0000_C000;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [NL-1:0] reqActive = '0;
  logic [NL-1:0] reqPred = '0;
  logic [NL*AW-1:0] reqAddr = '0;
  logic wfValid;
  logic wfReady = 1'b1;
  logic [NB*RW-1:0] wfRowSel;
  logic [NB-1:0] wfBankValid;
  logic [NB*NL-1:0] wfLaneMask;
  logic done, error;

  int checks = 0;
  int fails = 0;
  logic [AW-1:0] laneAddr [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  smemResolver uut (
    .clk(clk), .rstN(rstN), .winBase(winBase), .memSize(memSize),
    .reqValid(reqValid), .reqReady(reqReady), .reqActive(reqActive),
    .reqPred(reqPred), .reqAddr(reqAddr), .wfValid(wfValid),
    .wfReady(wfReady), .wfRowSel(wfRowSel), .wfBankValid(wfBankValid),
    .wfLaneMask(wfLaneMask), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input logic [1023:0] act,
                     input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Drives one request and checks every wavefront against a lowest-lane model.
  task automatic runCase(input string name, input logic [NL-1:0] act,
                         input logic [NL-1:0] prd, input int expWaves,
                         input bit stallFirst);
    logic [NL-1:0] live;
    logic [AW-1:0] off [NL];
    bit expErr;
    int waves;
    live = act & prd;
    expErr = 1'b0;
    for (int i = 0; i < NL; i++) begin
      off[i] = laneAddr[i] - winBase;
      if (live[i] && off[i] >= memSize) expErr = 1'b1;
    end
    @(negedge clk);
    chk(reqReady == 1'b1, {"R8 ready idle ", name}, reqReady, 1);
    reqActive = act;
    reqPred = prd;
    for (int i = 0; i < NL; i++) reqAddr[i*AW +: AW] = laneAddr[i];
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (expErr) begin
      chk(done && error && !wfValid, {"R3 error completion ", name},
          {done, error, wfValid}, 3'b110);
    end else if (live == '0) begin
      chk(done && !error && !wfValid, {"R9 empty completion ", name},
          {done, error, wfValid}, 3'b100);
    end else begin
      waves = 0;
      while (live != '0) begin
        logic [NB-1:0] eBank;
        logic [NB*NL-1:0] eMask;
        logic [NB*RW-1:0] eRow, rowKeep;
        logic [NL-1:0] served;
        bit eLast;
        eBank = '0; eMask = '0; eRow = '0; rowKeep = '0; served = '0;
        for (int i = 0; i < NL; i++) begin
          int bk;
          logic [RW-1:0] rw;
          if (!live[i]) continue;
          bk = int'(off[i][6:2]);
          rw = off[i][AW-1:7];
          if (!eBank[bk]) begin
            eBank[bk] = 1'b1;
            eRow[bk*RW +: RW] = rw;
            rowKeep[bk*RW +: RW] = '1;
          end
          if (eRow[bk*RW +: RW] == rw) begin
            eMask[bk*NL + i] = 1'b1;
            served[i] = 1'b1;
          end
        end
        eLast = ((live & ~served) == '0);
        chk(wfValid == 1'b1, {"R7 wave presented ", name}, wfValid, 1);
        chk(wfBankValid == eBank, {"R6 bank enables ", name}, wfBankValid, eBank);
        chk(wfLaneMask == eMask, {"R5 R6 lane masks ", name}, wfLaneMask, eMask);
        chk((wfRowSel & rowKeep) == eRow, {"R4 row select ", name},
            wfRowSel & rowKeep, eRow);
        chk(done == eLast && !error, {"R8 done with last wave ", name},
            {done, error}, {eLast, 1'b0});
        chk(reqReady == 1'b0, {"R8 busy ", name}, reqReady, 0);
        if (stallFirst && waves == 0) begin
          wfReady = 1'b0;
          @(negedge clk);
          chk(wfValid && wfLaneMask == eMask && wfBankValid == eBank,
              {"R7 stall hold ", name}, wfLaneMask, eMask);
          wfReady = 1'b1;
        end
        @(negedge clk);
        live = live & ~served;
        waves++;
      end
      if (expWaves >= 0)
        chk(waves == expWaves, {"R10 wave count ", name}, waves, expWaves);
    end
    if (expErr || live == '0) begin
      if (!wfValid && !expErr && (act & prd) != '0) begin
        // last wave already advanced; now idle
      end else begin
        @(negedge clk);
      end
    end
    chk(reqReady == 1'b1 && !wfValid, {"R8 ready after finish ", name},
        {reqReady, wfValid}, 2'b10);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1 && !wfValid && !done && !error, "R8 reset state",
        {reqReady, wfValid, done, error}, 4'b1000);
  endtask

  task automatic testStride();
    for (int i = 0; i < NL; i++) laneAddr[i] = winBase + 32'(4*i);
    runCase("unit stride", '1, '1, 1, 1'b0);
  endtask

  task automatic testBroadcast();
    for (int i = 0; i < NL; i++) laneAddr[i] = winBase + 32'h0000_1234;
    runCase("broadcast", '1, '1, 1, 1'b1);
  endtask

  task automatic testFullConflict();
    // R10: every lane in bank 0, a different row each
    for (int i = 0; i < NL; i++) laneAddr[i] = winBase + 32'(128*i);
    runCase("32-way conflict", '1, '1, 32, 1'b0);
  endtask

  task automatic testMasked();
    // R1: off lanes conflict with live ones and lane 1 is out of range, yet ignored
    logic [NL-1:0] act, prd;
    int n;
    act = 32'h5555_5555;
    prd = 32'hFFFF_FFF6;
    n = $countones(act & prd);
    for (int i = 0; i < NL; i++) laneAddr[i] = winBase + 32'(128*i + 8);
    laneAddr[1] = winBase + memSize;
    runCase("R1 masked lanes", act, prd, n, 1'b0);
  endtask

  task automatic testMixed();
    for (int i = 0; i < NL; i++)
      laneAddr[i] = winBase + 32'(((i*7)%5)*128 + ((i*3)%32)*4 + (i%4));
    runCase("mixed rows", '1, '1, -1, 1'b1);
    for (int i = 0; i < NL; i++)
      laneAddr[i] = winBase + 32'(((i*13)%3)*4096 + ((i*5)%8)*4);
    runCase("R2 R5 shared rows", 32'hF0F0_FFFF, '1, -1, 1'b0);
  endtask

  task automatic testOutOfRange();
    for (int i = 0; i < NL; i++) laneAddr[i] = winBase + 32'(4*i);
    laneAddr[17] = winBase + memSize;
    runCase("R3 at size", '1, '1, -1, 1'b0);
    laneAddr[17] = winBase + memSize - 4;
    runCase("R3 just below size", '1, '1, -1, 1'b0);
    laneAddr[17] = winBase - 4;
    runCase("R2 R3 below base", '1, '1, -1, 1'b0);
  endtask

  task automatic testEmpty();
    for (int i = 0; i < NL; i++) laneAddr[i] = winBase + memSize + 32'(i);
    runCase("R9 no live lanes", 32'h0000_FFFF, 32'hFFFF_0000, 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NL; i++) laneAddr[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStride();
    testBroadcast();
    testFullConflict();
    testMasked();
    testMixed();
    testOutOfRange();
    testEmpty();
    testStride();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule